// File: doc/BRIEF.md
# Self-Timed EEPROM Program Cycle Engine

This block sits behind the serial command decoder of a small serial EEPROM. It takes already decoded commands, one strobe at a time, and carries out the four programming operations: clearing one word, writing one word, clearing the whole array and filling the whole array with one value. It also holds the program-enable latch, which every programming command must pass. It times each operation with its own busy interval, counted in system clocks, and produces the ready/busy level that the serial output pin shows while the host polls.

Array updates go out as a simple one-word-per-clock write port (enable, address, data). A single-word write first writes all ones to the word and then the new value, and a whole-array fill first clears every word and then writes every word. This makes the automatic erase visible at the write port. The busy interval then runs on to its full programmed length, whether or not the serial clock keeps running and whatever the chip select does.

Status is offered to the output pin only after chip select has been low for a minimum number of clocks and is then raised while an operation is running. The pin drive request follows chip select low at once, without waiting for a clock edge.

Top module: `eeprom_prog_engine`

## Requirements
- R1: After reset, busy, arr_we and stat_oe are 0 and the enable latch is cleared, so a programming command issued before any enable command does not start a cycle.
- R2: cmd_op encodings are 0 no-op, 1 read, 2 enable, 3 disable, 4 word erase, 5 word write, 6 array erase, 7 array fill. An enable command sets the latch and a disable command clears it. A programming command (code 4 to 7) received with the latch clear causes no busy cycle and no array write.
- R3: Word erase writes all ones to cmd_addr in the first cycle after the strobe, with exactly one array write.
- R4: Word write writes all ones to cmd_addr in the first cycle after the strobe and cmd_data to cmd_addr in the second cycle, with exactly two array writes.
- R5: Array erase writes all ones to every address in ascending order from 0, one per cycle, starting the cycle after the strobe.
- R6: Array fill writes all ones to every address in ascending order, then cmd_data to every address in ascending order, one write per cycle and with no gap between the two passes.
- R7: busy rises in the cycle after an accepted programming strobe and stays high for exactly T_WORD cycles (word erase or write), T_ERASE_ALL (array erase) or T_WRITE_ALL (array fill). Every array write falls inside this interval, and the interval and its writes complete even when cs is low.
- R8: Any strobe that arrives while busy is 1, including enable and disable, is ignored.
- R9: When cs rises after at least CSL_MIN cycles low while busy is 1, stat_oe becomes 1 from the next cycle and stays 1 while cs is high. stat_val is 0 while the cycle runs and 1 once it has ended. stat_oe drops to 0 as soon as cs is low.
- R10: A cs rise after fewer than CSL_MIN low cycles, or while idle, leaves stat_oe at 0.
- R11: While pwr_ok is 0, programming strobes are dropped without a busy cycle, the enable latch is cleared, and arr_we is held at 0.
- R12: Read and no-op strobes cause no busy cycle and no array write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | One-cycle strobe of a decoded command |
| cmd_op | input | 3 | Command code (see R2) |
| cmd_addr | input | ADDR_W | Word address of the command |
| cmd_data | input | DATA_W | Data word of a write or fill |
| cs | input | 1 | Chip select level, high selects |
| pwr_ok | input | 1 | Supply good; 0 inhibits programming |
| arr_we | output | 1 | Array write enable, one word per cycle |
| arr_addr | output | ADDR_W | Array write address |
| arr_wdata | output | DATA_W | Array write data |
| busy | output | 1 | Programming cycle in progress |
| stat_oe | output | 1 | Request to drive status onto the output pin |
| stat_val | output | 1 | Status level: 0 busy, 1 ready |

## Verification
The embedded properties check on every cycle the relations between separate parts of the block. An accepted programming strobe is followed by busy. A strobe with the latch clear or the supply down is followed by no busy. Array writes and the sweep happen only inside a busy interval, the program pass never opens a cycle, and a status request only appears after a busy cycle. Only the bench scenarios can show the exact busy lengths, the order and content of the write sequences, the final array content, and the effect of ignored or dropped commands. The same holds for the chip-select low-time threshold and the immediate release of the status drive.

// File: rtl/eeprom_prog_pkg.sv
package eeprom_prog_pkg;

   typedef enum logic [2:0] {
      OP_NOP      = 3'd0,
      OP_READ     = 3'd1,
      OP_EN       = 3'd2,
      OP_DIS      = 3'd3,
      OP_WORD_CLR = 3'd4,
      OP_WORD_WR  = 3'd5,
      OP_ALL_CLR  = 3'd6,
      OP_ALL_FILL = 3'd7
   } prog_op_e;

   // bit 2: programming command; bit 1: whole array; bit 0: program pass after erase
   function automatic logic op_is_prog(input prog_op_e op);
      return op[2];
   endfunction

   function automatic logic op_is_whole(input prog_op_e op);
      return op[1];
   endfunction

   function automatic logic op_has_fill(input prog_op_e op);
      return op[0];
   endfunction

endpackage

// File: rtl/eeprom_enable_latch.sv
module eeprom_enable_latch (
   input  logic clk,
   input  logic rst_n,
   input  logic pwr_ok,
   input  logic set_i,
   input  logic clr_i,
   output logic en_o
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         en_o <= 1'b0;
      else if (!pwr_ok)
         en_o <= 1'b0;
      else if (set_i)
         en_o <= 1'b1;
      else if (clr_i)
         en_o <= 1'b0;
   end

endmodule

// File: rtl/eeprom_busy_timer.sv
module eeprom_busy_timer
   import eeprom_prog_pkg::*;
#(
   parameter int unsigned T_WORD      = 250000,
   parameter int unsigned T_ERASE_ALL = 750000,
   parameter int unsigned T_WRITE_ALL = 1875000
) (
   input  logic     clk,
   input  logic     rst_n,
   input  logic     start_i,
   input  prog_op_e op_i,
   output logic     busy_o
);

   localparam int unsigned T_MAX_A = (T_WORD > T_ERASE_ALL) ? T_WORD : T_ERASE_ALL;
   localparam int unsigned T_MAX   = (T_MAX_A > T_WRITE_ALL) ? T_MAX_A : T_WRITE_ALL;
   localparam int unsigned CNT_W   = $clog2(T_MAX + 1);

   logic [CNT_W-1:0] remain;
   logic [CNT_W-1:0] load_val;

   always_comb begin
      case (op_i)
         OP_ALL_CLR:  load_val = CNT_W'(T_ERASE_ALL - 1);
         OP_ALL_FILL: load_val = CNT_W'(T_WRITE_ALL - 1);
         default:     load_val = CNT_W'(T_WORD - 1);
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy_o <= 1'b0;
         remain <= '0;
      end else if (start_i) begin
         busy_o <= 1'b1;
         remain <= load_val;
      end else if (busy_o) begin
         if (remain == '0)
            busy_o <= 1'b0;
         else
            remain <= remain - 1'b1;
      end
   end

endmodule

// File: rtl/eeprom_array_sweep.sv
module eeprom_array_sweep #(
   parameter int unsigned ADDR_W = 7,
   parameter int unsigned DATA_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start_i,
   input  logic              whole_i,
   input  logic              fill_i,
   input  logic [ADDR_W-1:0] addr_i,
   input  logic [DATA_W-1:0] data_i,
   output logic              active_o,
   output logic [ADDR_W-1:0] waddr_o,
   output logic [DATA_W-1:0] wdata_o
);

   logic              erase_ph;
   logic              fill_pend;
   logic [ADDR_W-1:0] first_a;
   logic [ADDR_W-1:0] last_a;
   logic [ADDR_W-1:0] ptr;
   logic [DATA_W-1:0] data_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         active_o  <= 1'b0;
         erase_ph  <= 1'b0;
         fill_pend <= 1'b0;
         first_a   <= '0;
         last_a    <= '0;
         ptr       <= '0;
         data_q    <= '0;
      end else if (start_i) begin
         active_o  <= 1'b1;
         erase_ph  <= 1'b1;
         fill_pend <= fill_i;
         first_a   <= whole_i ? '0 : addr_i;
         last_a    <= whole_i ? '1 : addr_i;
         ptr       <= whole_i ? '0 : addr_i;
         data_q    <= data_i;
      end else if (active_o) begin
         if (ptr == last_a) begin
            if (fill_pend) begin
               fill_pend <= 1'b0;
               erase_ph  <= 1'b0;
               ptr       <= first_a;
            end else begin
               active_o  <= 1'b0;
            end
         end else begin
            ptr <= ptr + 1'b1;
         end
      end
   end

   assign waddr_o = ptr;
   assign wdata_o = erase_ph ? '1 : data_q;

   // the program pass always follows an erase pass of the same cycle
   assert_fill_after_erase_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (active_o && !erase_ph) |-> $past(active_o));

endmodule

// File: rtl/eeprom_status_drive.sv
module eeprom_status_drive #(
   parameter int unsigned CSL_MIN = 4
) (
   input  logic clk,
   input  logic rst_n,
   input  logic cs,
   input  logic busy_i,
   output logic stat_oe_o,
   output logic stat_val_o
);

   logic armed;
   logic low_long;

   generate
      if (CSL_MIN == 1) begin : g_flag
         logic was_low;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) was_low <= 1'b0;
            else        was_low <= !cs;
         end
         assign low_long = was_low;
      end else begin : g_count
         localparam int unsigned LC_W = $clog2(CSL_MIN + 1);
         logic [LC_W-1:0] low_cnt;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
               low_cnt <= '0;
            else if (cs)
               low_cnt <= '0;
            else if (low_cnt != LC_W'(CSL_MIN))
               low_cnt <= low_cnt + 1'b1;
         end
         assign low_long = (low_cnt == LC_W'(CSL_MIN));
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         armed <= 1'b0;
      else if (!cs)
         armed <= 1'b0;
      else if (low_long && busy_i)
         armed <= 1'b1;
   end

   assign stat_oe_o  = armed & cs;
   assign stat_val_o = !busy_i;

endmodule

// File: rtl/eeprom_prog_engine.sv
module eeprom_prog_engine
   import eeprom_prog_pkg::*;
#(
   parameter int unsigned ADDR_W      = 7,
   parameter int unsigned DATA_W      = 16,
   parameter int unsigned T_WORD      = 250000,
   parameter int unsigned T_ERASE_ALL = 750000,
   parameter int unsigned T_WRITE_ALL = 1875000,
   parameter int unsigned CSL_MIN     = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cmd_valid,
   input  logic [2:0]        cmd_op,
   input  logic [ADDR_W-1:0] cmd_addr,
   input  logic [DATA_W-1:0] cmd_data,
   input  logic              cs,
   input  logic              pwr_ok,
   output logic              arr_we,
   output logic [ADDR_W-1:0] arr_addr,
   output logic [DATA_W-1:0] arr_wdata,
   output logic              busy,
   output logic              stat_oe,
   output logic              stat_val
);

   localparam int unsigned DEPTH = 1 << ADDR_W;

   generate
      if (ADDR_W < 1 || ADDR_W > 16) begin : g_bad_addr
         $error("ADDR_W must lie in 1..16");
      end
      if (DATA_W < 1) begin : g_bad_data
         $error("DATA_W must be at least 1");
      end
      if (T_WORD < 2) begin : g_bad_tword
         $error("T_WORD must cover the erase and program writes");
      end
      if (T_ERASE_ALL < DEPTH) begin : g_bad_terase
         $error("T_ERASE_ALL must cover one pass over the array");
      end
      if (T_WRITE_ALL < 2 * DEPTH) begin : g_bad_twrite
         $error("T_WRITE_ALL must cover two passes over the array");
      end
      if (CSL_MIN < 1) begin : g_bad_csl
         $error("CSL_MIN must be at least 1");
      end
   endgenerate

   prog_op_e op;
   logic     accept;
   logic     en;
   logic     go;
   logic     sweep_active;

   assign op     = prog_op_e'(cmd_op);
   assign accept = cmd_valid && !busy;
   assign go     = accept && op_is_prog(op) && en && pwr_ok;

   eeprom_enable_latch u_latch (
      .clk    (clk),
      .rst_n  (rst_n),
      .pwr_ok (pwr_ok),
      .set_i  (accept && op == OP_EN),
      .clr_i  (accept && op == OP_DIS),
      .en_o   (en)
   );

   eeprom_busy_timer #(
      .T_WORD      (T_WORD),
      .T_ERASE_ALL (T_ERASE_ALL),
      .T_WRITE_ALL (T_WRITE_ALL)
   ) u_timer (
      .clk     (clk),
      .rst_n   (rst_n),
      .start_i (go),
      .op_i    (op),
      .busy_o  (busy)
   );

   eeprom_array_sweep #(
      .ADDR_W (ADDR_W),
      .DATA_W (DATA_W)
   ) u_sweep (
      .clk      (clk),
      .rst_n    (rst_n),
      .start_i  (go),
      .whole_i  (op_is_whole(op)),
      .fill_i   (op_has_fill(op)),
      .addr_i   (cmd_addr),
      .data_i   (cmd_data),
      .active_o (sweep_active),
      .waddr_o  (arr_addr),
      .wdata_o  (arr_wdata)
   );

   assign arr_we = sweep_active && pwr_ok;

   eeprom_status_drive #(
      .CSL_MIN (CSL_MIN)
   ) u_status (
      .clk        (clk),
      .rst_n      (rst_n),
      .cs         (cs),
      .busy_i     (busy),
      .stat_oe_o  (stat_oe),
      .stat_val_o (stat_val)
   );

   assert_start_busy_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_valid && !busy && pwr_ok && en && cmd_op[2]) |=> busy);

   assert_disabled_drop_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_valid && !busy && !en && cmd_op[2]) |=> !busy);

   assert_power_drop_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_valid && !busy && !pwr_ok) |=> !busy);

   assert_write_in_busy_R7: assert property (@(posedge clk) disable iff (!rst_n)
      arr_we |-> busy);

   assert_sweep_in_busy_R6: assert property (@(posedge clk) disable iff (!rst_n)
      sweep_active |-> busy);

   assert_status_after_busy_R9: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(stat_oe) |-> $past(busy));

endmodule

// File: tb/tb_eeprom_prog_engine.sv
`timescale 1ns/1ps
module tb_eeprom_prog_engine;

   localparam int AW    = 4;
   localparam int DW    = 8;
   localparam int DEP   = 1 << AW;
   localparam int TW    = 20;
   localparam int TEA   = 40;
   localparam int TWA   = 60;
   localparam int CSL   = 3;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          cmd_valid = 1'b0;
   logic [2:0]    cmd_op = 3'd0;
   logic [AW-1:0] cmd_addr = '0;
   logic [DW-1:0] cmd_data = '0;
   logic          cs = 1'b1;
   logic          pwr_ok = 1'b1;
   logic          arr_we;
   logic [AW-1:0] arr_addr;
   logic [DW-1:0] arr_wdata;
   logic          busy;
   logic          stat_oe;
   logic          stat_val;

   always #4 clk = ~clk;   // 125 MHz

   eeprom_prog_engine #(
      .ADDR_W(AW), .DATA_W(DW), .T_WORD(TW), .T_ERASE_ALL(TEA),
      .T_WRITE_ALL(TWA), .CSL_MIN(CSL)
   ) dut (
      .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
      .cmd_addr(cmd_addr), .cmd_data(cmd_data), .cs(cs), .pwr_ok(pwr_ok),
      .arr_we(arr_we), .arr_addr(arr_addr), .arr_wdata(arr_wdata),
      .busy(busy), .stat_oe(stat_oe), .stat_val(stat_val)
   );

   // observed array and write log, built from the write port only
   logic [DW-1:0] mem [DEP];
   logic [AW-1:0] log_a [8192];
   logic [DW-1:0] log_d [8192];
   int            wr_n = 0;

   always @(posedge clk) begin
      if (arr_we) begin
         mem[arr_addr]     <= arr_wdata;
         log_a[wr_n[12:0]] <= arr_addr;
         log_d[wr_n[12:0]] <= arr_wdata;
         wr_n              <= wr_n + 1;
      end
   end

   // reference model state
   logic [DW-1:0] exp_mem [DEP];
   bit            en_m = 1'b0;
   bit            mem_known = 1'b0;
   int            checks = 0;
   int            fails = 0;
   bit            done = 1'b0;

   task automatic check(input bit ok, input string req, input longint act, input longint expv);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
      end
   endtask

   function automatic int dur_of(input logic [2:0] op);
      case (op)
         3'd6:    return TEA;
         3'd7:    return TWA;
         default: return TW;
      endcase
   endfunction

   function automatic string req_of(input logic [2:0] op);
      case (op)
         3'd4:    return "R3";
         3'd5:    return "R4";
         3'd6:    return "R5";
         default: return "R6";
      endcase
   endfunction

   function automatic int nwr_of(input logic [2:0] op);
      case (op)
         3'd4:    return 1;
         3'd5:    return 2;
         3'd6:    return DEP;
         default: return 2 * DEP;
      endcase
   endfunction

   function automatic logic [AW+DW-1:0] exp_wr(input logic [2:0] op, input int a,
                                               input int d, input int i);
      logic [AW-1:0] ea;
      logic [DW-1:0] ed;
      case (op)
         3'd4: begin ea = AW'(a); ed = '1; end
         3'd5: begin ea = AW'(a); ed = (i == 0) ? '1 : DW'(d); end
         3'd6: begin ea = AW'(i); ed = '1; end
         default: begin
            ea = AW'(i % DEP);
            ed = (i < DEP) ? '1 : DW'(d);
         end
      endcase
      return {ea, ed};
   endfunction

   task automatic apply_model(input logic [2:0] op, input int a, input int d);
      case (op)
         3'd4: exp_mem[a] = '1;
         3'd5: exp_mem[a] = DW'(d);
         3'd6: begin
            for (int i = 0; i < DEP; i++) exp_mem[i] = '1;
            mem_known = 1'b1;
         end
         default: begin
            for (int i = 0; i < DEP; i++) exp_mem[i] = DW'(d);
            mem_known = 1'b1;
         end
      endcase
   endtask

   task automatic check_mem(input string req);
      int bad = 0;
      int first = -1;
      if (!mem_known) return;
      for (int i = 0; i < DEP; i++)
         if (mem[i] !== exp_mem[i]) begin
            bad++;
            if (first < 0) first = i;
         end
      if (bad == 0) check(1'b1, req, 0, 0);
      else check(1'b0, {req, " array word"}, mem[first], exp_mem[first]);
   endtask

   task automatic pulse(input logic [2:0] op, input int a, input int d);
      @(negedge clk);
      cmd_valid = 1'b1;
      cmd_op    = op;
      cmd_addr  = AW'(a);
      cmd_data  = DW'(d);
      @(negedge clk);
      cmd_valid = 1'b0;
   endtask

   task automatic wait_idle();
      int n = 0;
      while (busy && n < 100000) begin
         n++;
         @(negedge clk);
      end
   endtask

   // issue one command and check busy length, write sequence and array
   task automatic run_cmd(input logic [2:0] op, input int a, input int d, output int n_busy);
      bit    prog = op[2];
      bit    go   = prog && en_m && pwr_ok;
      int    base;
      int    exp_n;
      int    bad = 0;
      string tag;
      if (!pwr_ok) en_m = 1'b0;
      else if (op == 3'd2) en_m = 1'b1;
      else if (op == 3'd3) en_m = 1'b0;
      base = wr_n;
      pulse(op, a, d);
      n_busy = 0;
      while (busy && n_busy < 100000) begin
         n_busy++;
         @(negedge clk);
      end
      if (go) tag = {req_of(op), "/R7"};
      else if (!prog) tag = "R12";
      else if (!pwr_ok) tag = "R11";
      else tag = "R2";
      exp_n = go ? dur_of(op) : 0;
      check(n_busy == exp_n, {tag, " busy length"}, n_busy, exp_n);
      exp_n = go ? nwr_of(op) : 0;
      check((wr_n - base) == exp_n, {tag, " write count"}, wr_n - base, exp_n);
      if (go && (wr_n - base) == exp_n) begin
         for (int i = 0; i < exp_n; i++)
            if ({log_a[(base + i) % 8192], log_d[(base + i) % 8192]} !== exp_wr(op, a, d, i))
               bad++;
         check(bad == 0, {tag, " write sequence"}, bad, 0);
         apply_model(op, a, d);
      end
      check_mem(tag);
   endtask

   initial begin : watchdog
      repeat (200000) @(posedge clk);
      if (!done) begin
         fails++;
         $display("FAIL watchdog actual=expired expected=finished");
         $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
         $finish;
      end
   end

   initial begin : main
      int nb;
      int seed_dummy;
      seed_dummy = $urandom(32'h5EED_1234);
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1: reset state
      check(busy == 1'b0 && arr_we == 1'b0 && stat_oe == 1'b0, "R1 reset outputs",
            {busy, arr_we, stat_oe}, 0);
      pulse(3'd5, 1, 8'h77);
      @(negedge clk);
      check(busy == 1'b0 && wr_n == 0, "R1 write before enable", busy, 0);

      // R5, R3, R4, R6 directed
      run_cmd(3'd2, 0, 0, nb);
      run_cmd(3'd6, 0, 0, nb);
      run_cmd(3'd4, 3, 0, nb);
      run_cmd(3'd5, 5, 8'hA5, nb);
      run_cmd(3'd5, DEP - 1, 8'h00, nb);
      run_cmd(3'd7, 0, 8'h3C, nb);
      run_cmd(3'd5, 0, 8'h81, nb);
      // R12: read and no-op while enabled
      run_cmd(3'd1, 4, 0, nb);
      run_cmd(3'd0, 4, 8'hFF, nb);
      // R2: disable then programming dropped
      run_cmd(3'd3, 0, 0, nb);
      run_cmd(3'd5, 6, 8'h12, nb);
      run_cmd(3'd7, 0, 8'h00, nb);

      // R8: strobes during busy are ignored
      run_cmd(3'd2, 0, 0, nb);
      pulse(3'd5, 2, 8'h11);
      repeat (3) @(negedge clk);
      pulse(3'd3, 0, 0);
      pulse(3'd5, 7, 8'h22);
      wait_idle();
      apply_model(3'd5, 2, 8'h11);
      check(mem[7] === exp_mem[7], "R8 write during busy", mem[7], exp_mem[7]);
      run_cmd(3'd5, 7, 8'h33, nb);
      check(nb == TW && mem[7] === 8'h33, "R8 disable during busy ignored", mem[7], 8'h33);

      // R9 + R7: status after long low, cycle survives cs low
      pulse(3'd7, 0, 8'h5A);
      @(negedge clk);
      cs = 1'b0;
      repeat (CSL) @(negedge clk);
      check(busy == 1'b1, "R7 busy with cs low", busy, 1);
      cs = 1'b1;
      @(negedge clk);
      check(stat_oe == 1'b1 && stat_val == 1'b0, "R9 status busy", {stat_oe, stat_val}, 2'b10);
      wait_idle();
      @(negedge clk);
      check(stat_oe == 1'b1 && stat_val == 1'b1, "R9 status ready", {stat_oe, stat_val}, 2'b11);
      cs = 1'b0;
      #1;
      check(stat_oe == 1'b0, "R9 release on cs low", stat_oe, 0);
      @(negedge clk);
      cs = 1'b1;
      apply_model(3'd7, 0, 8'h5A);
      check_mem("R7 fill with cs low");
      @(negedge clk);
      check(stat_oe == 1'b0, "R10 rise while idle", stat_oe, 0);

      // R10: short low time
      pulse(3'd4, 9, 0);
      cs = 1'b0;
      @(negedge clk);
      cs = 1'b1;
      repeat (2) @(negedge clk);
      check(stat_oe == 1'b0 && busy == 1'b1, "R10 short low", stat_oe, 0);
      wait_idle();
      apply_model(3'd4, 9, 0);
      check_mem("R10 erase done");

      // R11: power down drops commands and clears the latch
      pwr_ok = 1'b0;
      run_cmd(3'd5, 1, 8'h99, nb);
      check(nb == 0, "R11 no busy with supply down", nb, 0);
      pwr_ok = 1'b1;
      run_cmd(3'd5, 1, 8'h98, nb);
      check(nb == 0, "R11 latch cleared by supply loss", nb, 0);

      // random mix
      for (int it = 0; it < 70; it++) begin
         logic [2:0] op;
         op = 3'($urandom_range(0, 7));
         if (!en_m && $urandom_range(0, 2) == 0) op = 3'd2;
         pwr_ok = ($urandom_range(0, 7) != 0);
         run_cmd(op, $urandom_range(0, DEP - 1), $urandom_range(0, 255), nb);
      end
      pwr_ok = 1'b1;

      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
   end

endmodule